// File: doc/BRIEF.md
# Burst Copy Engine

This block is a single-channel memory-to-memory copy engine that sits on one shared memory bus. Software or a controller sets a source start address, a destination start address, a number of words per burst, a number of bursts, a word width (16 or 32 bits) and a slow-source flag, then pulses `start`. The engine then copies `bursts × words` words. It alternates a read of the source and a write of the destination on the bus. Its completion time is cycle-exact, so a system designer can budget bus bandwidth from the configuration alone.

The engine is a state machine with these states:

- IDLE: waiting for a start pulse.
- GAP: the one idle cycle that opens every burst.
- RD_OUT: the read address is on the bus.
- RD_WAIT: the extra stall cycle for a slow source.
- RD_DATA: read data is captured.
- WR_OUT: the write address is on the bus.
- WR_DATA: write data is driven.
- HOLD: frozen while preempted.
- RESUME: the one-cycle penalty after a preemption ends.
- DONE: the one-cycle completion pulse.

Transitions run as follows:

- IDLE goes to GAP on start, or straight to DONE when the burst length or the burst count is zero.
- GAP goes to RD_OUT, or to HOLD if preempted.
- RD_OUT goes to RD_WAIT when the source is slow, or to RD_DATA otherwise. RD_WAIT goes to RD_DATA.
- RD_DATA goes to WR_OUT, and WR_OUT goes to WR_DATA.
- WR_DATA goes to RD_OUT for the next word (or to HOLD if preempted), to GAP for the next burst, or to DONE after the last word.
- HOLD stays while preempt is high, then goes to RESUME. RESUME goes to RD_OUT.
- DONE goes to IDLE.

The generate-address stage of one phase always overlaps the output-address stage of the other phase. For that reason each word costs exactly four bus cycles. The bus uses a split address/data protocol: an address cycle with a read or write strobe, then a data cycle. The memory returns read data, registered, in the cycle after the read address. The memory takes write data in the cycle after the write address.

Top module: `burst_copy_engine`

## Requirements
- R1: After reset, `busy`, `done`, `bus_rd` and `bus_wr` are all 0.
- R2: Configuration is captured on the start pulse accepted in IDLE. A start pulse or a configuration change while `busy` is high has no effect on the running transfer.
- R3: Each word uses this bus sequence:
  - a read address cycle (`bus_rd`=1, `bus_addr`=source address);
  - a read data cycle;
  - a write address cycle (`bus_wr`=1, `bus_addr`=destination address);
  - a write data cycle in which `bus_wdata` carries the word read.

  `bus_rd` and `bus_wr` are never high together.
- R4: Every burst opens with one bus-idle cycle. With no stall and no preemption, `busy` stays high for exactly bursts × (4 × words + 1) cycles. For example, 8 bursts of 16 words take 520 cycles.
- R5: Source and destination addresses advance by one word after each word: by 1 for 16-bit words and by 2 for 32-bit words. They continue across burst boundaries from where the previous burst ended.
- R6: With `cfg_wide`=1, words are 32 bits and `bus_wide`=1, and the timing equals that of 16-bit words. With `cfg_wide`=0, bits 31:16 of `bus_wdata` are 0 whatever the memory returns in those bits.
- R7: With `cfg_slow_src`=1, every read gets one extra cycle between its address cycle and its data cycle. `busy` then lasts bursts × (5 × words + 1) cycles.
- R8: `preempt` is sampled only at word boundaries: leaving GAP, or leaving WR_DATA of a non-final word in a burst. If it is high there, the engine holds until it falls and then spends one resume cycle. Holding preempt for N sampled boundary cycles adds N + 1 cycles.
- R9: `done` is high for exactly one cycle, in the cycle after the final write data cycle, and `busy` is low from that cycle on. A start with zero burst length or zero burst count raises `done` in the next cycle with no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted in IDLE |
| cfg_src_addr | input | ADDR_W | Source start address (16-bit units) |
| cfg_dst_addr | input | ADDR_W | Destination start address (16-bit units) |
| cfg_burst_len | input | LEN_W | Words per burst |
| cfg_burst_cnt | input | CNT_W | Number of bursts |
| cfg_wide | input | 1 | 1 = 32-bit words, 0 = 16-bit words |
| cfg_slow_src | input | 1 | Source needs one read stall cycle |
| preempt | input | 1 | Freeze request, honoured at word boundaries |
| bus_addr | output | ADDR_W | Bus address during address cycles, else 0 |
| bus_rd | output | 1 | Read address strobe |
| bus_wr | output | 1 | Write address strobe |
| bus_wide | output | 1 | Access width of the current transfer |
| bus_wdata | output | DATA_W | Write data, valid in the write data cycle |
| bus_rdata | input | DATA_W | Read data, valid in the read data cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can meet on the same cycle: the end of a burst, and a word-boundary preemption sample. The first boundary after start is the GAP exit that opens a burst, so the bench raises `preempt` together with `start`. The GAP's burst-opening idle cycle and the hold/resume penalty then stack on one boundary. The bench judges this by the exact `busy` length, which must equal the base formula plus N + 1. A scoreboard confirms that the copied data and the destination addresses are unchanged by the freeze. A second overlap comes from pulsing `start` and changing the configuration mid-transfer. The cycle count and the scoreboard must show the original transfer running undisturbed.

// File: rtl/bce_pkg.sv
package bce_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GAP,
        ST_RD_OUT,
        ST_RD_WAIT,
        ST_RD_DATA,
        ST_WR_OUT,
        ST_WR_DATA,
        ST_HOLD,
        ST_RESUME,
        ST_DONE
    } bce_state_e;

endpackage

// File: rtl/bce_seq_fsm.sv
module bce_seq_fsm
    import bce_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [CNT_W-1:0] cfg_cnt,
    input  logic             cfg_wide,
    input  logic             cfg_slow,
    input  logic             preempt,
    output bce_state_e       state,
    output logic             wide,
    output logic             busy,
    output logic             done
);

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    bce_state_e       state_q, state_d;
    logic [LEN_W-1:0] len_q, words_left_q;
    logic [CNT_W-1:0] bursts_left_q;
    logic             wide_q, slow_q;
    logic             last_word, last_burst, zero_cfg;

    assign last_word  = (words_left_q == LEN_ONE);
    assign last_burst = (bursts_left_q == CNT_ONE);
    assign zero_cfg   = (cfg_len == '0) || (cfg_cnt == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = zero_cfg ? ST_DONE : ST_GAP;
            ST_GAP:     state_d = preempt ? ST_HOLD : ST_RD_OUT;
            ST_HOLD:    if (!preempt) state_d = ST_RESUME;
            ST_RESUME:  state_d = ST_RD_OUT;
            ST_RD_OUT:  state_d = slow_q ? ST_RD_WAIT : ST_RD_DATA;
            ST_RD_WAIT: state_d = ST_RD_DATA;
            ST_RD_DATA: state_d = ST_WR_OUT;
            ST_WR_OUT:  state_d = ST_WR_DATA;
            ST_WR_DATA: begin
                if (last_word) state_d = last_burst ? ST_DONE : ST_GAP;
                else           state_d = preempt ? ST_HOLD : ST_RD_OUT;
            end
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Captured configuration and word/burst counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q         <= '0;
            words_left_q  <= '0;
            bursts_left_q <= '0;
            wide_q        <= 1'b0;
            slow_q        <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            len_q         <= cfg_len;
            words_left_q  <= cfg_len;
            bursts_left_q <= cfg_cnt;
            wide_q        <= cfg_wide;
            slow_q        <= cfg_slow;
        end else if (state_q == ST_WR_DATA) begin
            if (last_word) begin
                words_left_q  <= len_q;
                bursts_left_q <= bursts_left_q - CNT_ONE;
            end else begin
                words_left_q  <= words_left_q - LEN_ONE;
            end
        end
    end

    // Outputs
    always_comb begin
        state = state_q;
        wide  = wide_q;
        busy  = (state_q != ST_IDLE) && (state_q != ST_DONE);
        done  = (state_q == ST_DONE);
    end

    // R8
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !preempt) |=> (state_q == ST_RESUME));

    // R7
    slow_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_OUT && slow_q) |=> (state_q == ST_RD_WAIT));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(len_q) && $stable(wide_q) && $stable(slow_q)));

    // R4
    gap_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && !preempt) |=> (state_q == ST_RD_OUT));

endmodule

// File: rtl/bce_addr_gen.sv
module bce_addr_gen #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic              wide,
    input  logic              adv_src,
    input  logic              adv_dst,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);

    localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(2);

    logic [ADDR_W-1:0] src_q, dst_q, step;

    assign step = wide ? STEP_WIDE : STEP_NARROW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (load) begin
            src_q <= cfg_src;
            dst_q <= cfg_dst;
        end else begin
            if (adv_src) src_q <= src_q + step;
            if (adv_dst) dst_q <= dst_q + step;
        end
    end

    assign src_addr = src_q;
    assign dst_addr = dst_q;

    // R5
    src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_src && !load) |=> (src_q == $past(src_q) + $past(step)));

    // R5
    dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_dst && !load) |=> (dst_q == $past(dst_q) + $past(step)));

endmodule

// File: rtl/bce_data_reg.sv
module bce_data_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              wide,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= wide ? rdata : {{HALF_W{1'b0}}, rdata[HALF_W-1:0]};
    end

    assign data = data_q;

    // R6
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !wide) |=> (data_q[DATA_W-1:HALF_W] == '0));

endmodule

// File: rtl/burst_copy_engine.sv
module burst_copy_engine
    import bce_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [LEN_W-1:0]  cfg_burst_len,
    input  logic [CNT_W-1:0]  cfg_burst_cnt,
    input  logic              cfg_wide,
    input  logic              cfg_slow_src,
    input  logic              preempt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_wide,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done
);

    bce_state_e        state;
    logic              wide;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic              load;

    assign load = (state == ST_IDLE) && start;

    bce_seq_fsm #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_len  (cfg_burst_len),
        .cfg_cnt  (cfg_burst_cnt),
        .cfg_wide (cfg_wide),
        .cfg_slow (cfg_slow_src),
        .preempt  (preempt),
        .state    (state),
        .wide     (wide),
        .busy     (busy),
        .done     (done)
    );

    bce_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cfg_src  (cfg_src_addr),
        .cfg_dst  (cfg_dst_addr),
        .wide     (cfg_wide_sel(load, cfg_wide, wide)),
        .adv_src  (state == ST_RD_OUT),
        .adv_dst  (state == ST_WR_OUT),
        .src_addr (src_addr),
        .dst_addr (dst_addr)
    );

    bce_data_reg #(.DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (state == ST_RD_DATA),
        .wide    (wide),
        .rdata   (bus_rdata),
        .data    (bus_wdata)
    );

    function automatic logic cfg_wide_sel(input logic ld, input logic c, input logic q);
        return ld ? c : q;
    endfunction

    // Bus outputs
    always_comb begin
        bus_rd   = (state == ST_RD_OUT);
        bus_wr   = (state == ST_WR_OUT);
        bus_wide = wide;
        if (bus_rd)      bus_addr = src_addr;
        else if (bus_wr) bus_addr = dst_addr;
        else             bus_addr = '0;
    end

    // R3
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R3
    wr_data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (!bus_rd && !bus_wr && busy));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !$past(bus_rd));

endmodule

// File: tb/tb_burst_copy_engine.sv
module tb_burst_copy_engine;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_N      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [7:0]  cfg_burst_len = '0, cfg_burst_cnt = '0;
    logic        cfg_wide = 1'b0, cfg_slow_src = 1'b0, preempt = 1'b0;
    logic [15:0] bus_addr;
    logic        bus_rd, bus_wr, bus_wide, busy, done;
    logic [31:0] bus_wdata;
    logic [31:0] rdata_q = '0;

    burst_copy_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_burst_len(cfg_burst_len), .cfg_burst_cnt(cfg_burst_cnt),
        .cfg_wide(cfg_wide), .cfg_slow_src(cfg_slow_src), .preempt(preempt),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_q), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural memory, 16-bit cells
    logic [15:0] mem [MEM_N];
    logic        wr_pend = 1'b0, wr_wide = 1'b0;
    logic [9:0]  wr_a = '0;

    always @(posedge clk) begin
        if (bus_rd) rdata_q <= {mem[10'(bus_addr[9:0] + 10'd1)], mem[bus_addr[9:0]]};
        if (wr_pend) begin
            mem[wr_a] <= bus_wdata[15:0];
            if (wr_wide) mem[10'(wr_a + 10'd1)] <= bus_wdata[31:16];
        end
        wr_pend <= bus_wr;
        wr_a    <= bus_addr[9:0];
        wr_wide <= bus_wide;
    end

    // Scoreboard
    typedef struct { logic [15:0] a; logic [31:0] d; } exp_t;
    exp_t exp_q[$];
    int checks = 0, fails = 0;
    int busy_cnt = 0, done_cnt = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        cyc++;
        if (busy) busy_cnt++;
        if (done) done_cnt++;
        if (wr_pend) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected write", longint'(wr_a), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(wr_a == e.a[9:0], "R5", "write address", longint'(wr_a), longint'(e.a[9:0]));
                chk(bus_wdata == e.d, "R3/R6", "write data", longint'(bus_wdata), longint'(e.d));
            end
        end
        if (cyc > 150000) begin
            chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [31:0] rd_word(input logic [15:0] a, input bit w);
        logic [9:0] i;
        i = a[9:0];
        return w ? {mem[10'(i + 10'd1)], mem[i]} : {16'h0, mem[i]};
    endfunction

    // Driver
    task automatic run_xfer(input logic [15:0] s, input logic [15:0] d,
                            input int len, input int cnt, input bit w, input bit slow,
                            input int pre_n, input bit poke, input bit probe, input string tag);
        int step, expc, guard;
        step = w ? 2 : 1;
        for (int k = 0; k < len * cnt; k++) begin
            exp_t e;
            e.a = 16'(d + k * step);
            e.d = rd_word(16'(s + k * step), w);
            exp_q.push_back(e);
        end
        @(negedge clk);
        cfg_src_addr = s; cfg_dst_addr = d;
        cfg_burst_len = 8'(len); cfg_burst_cnt = 8'(cnt);
        cfg_wide = w; cfg_slow_src = slow;
        preempt = (pre_n > 0);
        busy_cnt = 0; done_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (probe) begin
            chk(!bus_rd && !bus_wr, "R4", {tag, " gap idle"}, {bus_rd, bus_wr}, 0);
            @(negedge clk);
            chk(bus_rd && !bus_wr && bus_addr == s, "R3", {tag, " read addr"}, bus_addr, s);
            @(negedge clk);
            chk(!bus_rd && !bus_wr, "R3", {tag, " read data cycle"}, {bus_rd, bus_wr}, 0);
            @(negedge clk);
            chk(bus_wr && !bus_rd && bus_addr == d, "R3", {tag, " write addr"}, bus_addr, d);
        end
        if (pre_n > 0) begin
            repeat (pre_n) @(negedge clk);
            preempt = 1'b0;
        end
        if (poke) begin
            repeat (3) @(negedge clk);
            cfg_src_addr = 16'd300; cfg_burst_len = 8'd1; cfg_wide = ~w;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        if (len == 0 || cnt == 0) expc = 0;
        else expc = cnt * ((slow ? 5 : 4) * len + 1) + ((pre_n > 0) ? pre_n + 1 : 0);
        chk(busy_cnt == expc, poke ? "R2" : (pre_n > 0 ? "R8" : (slow ? "R7" : "R4")),
            {tag, " busy cycles"}, busy_cnt, expc);
        @(negedge clk);
        chk(!done && !busy && done_cnt == 1, "R9", {tag, " single done pulse"}, done_cnt, 1);
        chk(exp_q.size() == 0, "R3", {tag, " all words written"}, exp_q.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < MEM_N; i++) mem[i] = 16'(i * 40503 + 4660);
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1", "busy/done at reset", {busy, done}, 0);
        chk(!bus_rd && !bus_wr, "R1", "bus strobes at reset", {bus_rd, bus_wr}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done, "R1", "idle after reset release", {busy, done}, 0);

        run_xfer(16'd0,   16'd512, 4, 2, 1'b0, 1'b0, 0, 1'b0, 1'b1, "R3 narrow 2x4");
        run_xfer(16'd100, 16'd700, 3, 2, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R6 wide 2x3");
        run_xfer(16'd40,  16'd600, 2, 2, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R7 slow 2x2");
        run_xfer(16'd60,  16'd620, 2, 1, 1'b0, 1'b0, 3, 1'b0, 1'b0, "R8 preempt");
        run_xfer(16'd80,  16'd640, 3, 2, 1'b1, 1'b1, 2, 1'b0, 1'b0, "R8 slow wide preempt");
        run_xfer(16'd150, 16'd660, 3, 2, 1'b0, 1'b0, 0, 1'b1, 1'b0, "R2 start while busy");
        run_xfer(16'd0,   16'd520, 16, 8, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R4 8x16");
        run_xfer(16'd200, 16'd900, 0, 3, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R9 zero length");
        run_xfer(16'd200, 16'd900, 4, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R9 zero count");

        // R5 narrow copy landed in memory, continuing across the burst boundary
        chk(mem[517] == 16'(5 * 40503 + 4660), "R5", "memory word 5 after 2x4", mem[517], 16'(5 * 40503 + 4660));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule